// File: doc/BRIEF.md
# MDIO Management Frame Engine

This block carries out a single management transaction to an external PHY over a two-wire serial management bus. The host sets a port enable and then writes one 32-bit management word. That word holds the whole frame: a start pattern, an operation code, the PHY address, the register address, a turnaround pattern and sixteen data bits. The engine first sends thirty-two ones as a preamble. It then sends the frame most-significant bit first on a divided management clock. While the frame is in flight, the idle flag is low.

For a read, the engine lets go of the data line at the turnaround. It then samples sixteen bits from the PHY and writes them into the low half of the management word, where the host reads them back. A pull-up on the line means that a read with no PHY present returns all ones. The management clock runs at the peripheral clock divided by 8, 16, 32 or 64. Software picks the ratio from the peripheral clock frequency so that the management clock stays within the PHY's limit.

Top module: `mdio_frame_engine`

## Requirements
- R1: After reset the engine is idle (`idle`=1), `mdc` is low, `mdio_oe` is low and `mgmt_rd` reads 0.
- R2: A write on `wr_en` starts a transaction only when `mgmt_en` is 1 and the engine is idle. When `mgmt_en` is 0, the write is ignored: `mgmt_rd` and the bus stay unchanged.
- R3: `idle` goes low on the clock after an accepted write. It stays low for exactly 64 management bit times (64 × divider peripheral clocks). It then returns high.
- R4: The first 32 bits on `mdio_o` are ones. The next 32 bits are word bits 31 down to 0, in that order. The layout is: [31:30] start (01), [29:28] operation, [27:23] PHY address, [22:18] register address, [17:16] turnaround (10), [15:0] data.
- R5: Operation 01 (write) keeps `mdio_oe` high for all 64 bits. `mgmt_rd` equals the written word afterwards.
- R6: Operation 10 (read) holds `mdio_oe` low for bits 46 to 63. Bits 46 and 47 are the turnaround; bits 48 to 63 are the data. The engine samples 16 bits on `mdio_i`, most significant first, into `mgmt_rd[15:0]`. Bits [31:16] are kept.
- R7: A read with no PHY driving the line (which idles high) returns 16'hFFFF in the data field.
- R8: `clk_sel` values 0, 1, 2 and 3 give an `mdc` period of 8, 16, 32 and 64 peripheral clocks. `mdc` is low for the first half of each bit time and high for the second half.
- R9: `mdio_o` changes only together with a falling `mdc` edge. Input bits are taken at the rising `mdc` edge.
- R10: A write on `wr_en` while a transaction is in progress is ignored. The frame on the bus and the final `mgmt_rd` are those of the first word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| mgmt_en | input | 1 | Management port enable; writes are ignored while low |
| clk_sel | input | 2 | Divider select: 0→8, 1→16, 2→32, 3→64; latched at start |
| wr_en | input | 1 | One-cycle write strobe for the management word |
| wr_data | input | 32 | Management word to send |
| mgmt_rd | output | 32 | Management word readback; holds read data after a read |
| idle | output | 1 | High when no transaction is in progress |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Serial data out |
| mdio_oe | output | 1 | Output enable for the serial data pad |
| mdio_i | input | 1 | Serial data in from the pad |

## Verification
Writes and reads are run at every divider setting. Writes show that the frame is sent bit-exact and that the line is driven throughout. Reads with a PHY model show the turnaround release and the order of the captured data. A read with no PHY shows that a floating line becomes all ones. Measuring the `mdc` period and the number of busy cycles separates the four divider ratios. Writes with the port disabled, and writes during a transaction, show that neither changes the bus or the readback.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int WORD_W     = 32;
    localparam int DATA_W     = 16;
    localparam int PRE_LEN    = 32;
    localparam int SEL_W      = 2;
    localparam int DIV_LOG2_0 = 3;

    localparam logic [1:0] OP_WRITE = 2'b01;
    localparam logic [1:0] OP_READ  = 2'b10;

    typedef struct packed {
        logic [1:0]        sof;
        logic [1:0]        op;
        logic [4:0]        phy;
        logic [4:0]        regad;
        logic [1:0]        ta;
        logic [DATA_W-1:0] data;
    } mgmt_word_t;

    function automatic int div_log2(input int base_log2, input int sel);
        return base_log2 + sel;
    endfunction

endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div
    import mdio_pkg::*;
#(
    parameter int SW   = SEL_W,
    parameter int BASE = DIV_LOG2_0,
    localparam int CNT_W = BASE + (1 << SW) - 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          stop,
    input  logic [SW-1:0] sel,
    output logic          mdc,
    output logic          rise_stb,
    output logic          fall_stb
);

    logic             run;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] full_m1;
    logic [CNT_W-1:0] half_m1;

    always_ff @(posedge clk) begin
        if (rst) begin
            run     <= 1'b0;
            cnt     <= '0;
            full_m1 <= '0;
            half_m1 <= '0;
        end else if (start) begin
            run     <= 1'b1;
            cnt     <= '0;
            full_m1 <= CNT_W'((1 << div_log2(BASE, int'(sel))) - 1);
            half_m1 <= CNT_W'((1 << (div_log2(BASE, int'(sel)) - 1)) - 1);
        end else if (run) begin
            if (stop) begin
                run <= 1'b0;
                cnt <= '0;
            end else if (cnt == full_m1) begin
                cnt <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign fall_stb = run && (cnt == full_m1);
    assign rise_stb = run && (cnt == half_m1);
    assign mdc      = run && (cnt > half_m1);

    // R8: a low-to-high mdc transition always follows a rise strobe
    a_r8_rise_after_strobe: assert property (@(posedge clk) disable iff (rst)
        $rose(mdc) |-> $past(rise_stb));

endmodule

// File: rtl/mdio_shifter.sv
module mdio_shifter
    import mdio_pkg::*;
#(
    parameter int WW  = WORD_W,
    parameter int DW  = DATA_W,
    parameter int PRE = PRE_LEN,
    localparam int TOTAL    = PRE + WW,
    localparam int IDX_W    = $clog2(TOTAL),
    localparam int TA_START = TOTAL - DW - 2,
    localparam int DT_START = TOTAL - DW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          mgmt_en,
    input  logic          wr_en,
    input  logic [WW-1:0] wr_data,
    input  logic          rise_stb,
    input  logic          fall_stb,
    input  logic          mdio_i,
    output logic          start,
    output logic          done,
    output logic          busy,
    output logic [WW-1:0] word,
    output logic          mdio_o,
    output logic          mdio_oe
);

    logic             rd;
    logic [IDX_W-1:0] bitcnt;
    logic [IDX_W-1:0] nxt;
    mgmt_word_t       wr_fields;

    assign wr_fields = mgmt_word_t'(wr_data);
    assign start     = wr_en && mgmt_en && !busy;
    assign done      = busy && fall_stb && (bitcnt == IDX_W'(TOTAL - 1));
    assign nxt       = bitcnt + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            rd      <= 1'b0;
            bitcnt  <= '0;
            word    <= '0;
            mdio_o  <= 1'b1;
            mdio_oe <= 1'b0;
        end else if (start) begin
            busy    <= 1'b1;
            rd      <= (wr_fields.op == OP_READ);
            bitcnt  <= '0;
            word    <= wr_data;
            mdio_o  <= 1'b1;
            mdio_oe <= 1'b1;
        end else if (busy) begin
            if (rise_stb && rd && (int'(bitcnt) >= DT_START))
                word[DW-1:0] <= {word[DW-2:0], mdio_i};
            if (done) begin
                busy    <= 1'b0;
                mdio_o  <= 1'b1;
                mdio_oe <= 1'b0;
            end else if (fall_stb) begin
                bitcnt  <= nxt;
                mdio_o  <= (int'(nxt) < PRE) ? 1'b1
                         : word[TOTAL - 1 - int'(nxt)];
                mdio_oe <= !(rd && (int'(nxt) >= TA_START));
            end
        end
    end

    // R2: a transaction only begins after an enabled write
    a_r2_start_needs_enable: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(wr_en && mgmt_en));

    // R5 and R10: the word stays unchanged during a write transaction
    a_r5_word_stable_on_write: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && !rd) |-> $stable(word));

    // R6: the upper fields of the word are kept during a read
    a_r6_upper_kept_on_read: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && rd) |-> $stable(word[WW-1:DW]));

    // R6: the line is released throughout the turnaround and data bits of a read
    a_r6_released_in_ta: assert property (@(posedge clk) disable iff (rst)
        (busy && rd && (int'(bitcnt) >= TA_START)) |-> !mdio_oe);

endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
    import mdio_pkg::*;
#(
    parameter int WW   = WORD_W,
    parameter int DW   = DATA_W,
    parameter int PRE  = PRE_LEN,
    parameter int SW   = SEL_W,
    parameter int BASE = DIV_LOG2_0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          mgmt_en,
    input  logic [SW-1:0] clk_sel,
    input  logic          wr_en,
    input  logic [WW-1:0] wr_data,
    output logic [WW-1:0] mgmt_rd,
    output logic          idle,
    output logic          mdc,
    output logic          mdio_o,
    output logic          mdio_oe,
    input  logic          mdio_i
);

    logic start, done, busy, rise_stb, fall_stb;

    mdio_clk_div #(.SW(SW), .BASE(BASE)) u_div (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .stop     (done),
        .sel      (clk_sel),
        .mdc      (mdc),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb)
    );

    mdio_shifter #(.WW(WW), .DW(DW), .PRE(PRE)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .mgmt_en  (mgmt_en),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb),
        .mdio_i   (mdio_i),
        .start    (start),
        .done     (done),
        .busy     (busy),
        .word     (mgmt_rd),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe)
    );

    assign idle = !busy;

    // R1 and R3: when idle, the clock is parked low and the line is released
    a_r3_quiet_when_idle: assert property (@(posedge clk) disable iff (rst)
        idle |-> (!mdc && !mdio_oe));

    // R9: the data line moves only with a falling mdc edge or at the end of a frame
    a_r9_drive_on_fall: assert property (@(posedge clk) disable iff (rst)
        !$stable(mdio_o) |-> ($fell(mdc) || $rose(idle)));

endmodule

// File: tb/mdio_frame_engine_bench.sv
module mdio_frame_engine_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        mgmt_en;
    logic [1:0]  clk_sel;
    logic        wr_en;
    logic [31:0] wr_data;
    logic [31:0] mgmt_rd;
    logic        idle, mdc, mdio_o, mdio_oe, mdio_i;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #4 clk = ~clk;

    mdio_frame_engine u_mdio_frame_engine (
        .clk(clk), .rst(rst), .mgmt_en(mgmt_en), .clk_sel(clk_sel),
        .wr_en(wr_en), .wr_data(wr_data), .mgmt_rd(mgmt_rd), .idle(idle),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    // PHY model and bus monitor
    logic        phy_on;
    logic [15:0] phy_data;
    int          rises;
    int          last_rise;
    int          period;
    int          bad_edges;
    int          busy_cyc;
    logic [63:0] cap;
    logic [63:0] oe_map;

    always @(posedge clk) cyc++;

    always @(posedge mdc) begin
        cap    = {cap[62:0], mdio_o};
        oe_map = {oe_map[62:0], mdio_oe};
        if (rises > 0) period = cyc - last_rise;
        last_rise = cyc;
        rises++;
    end

    always @(mdio_o) if (mdc) bad_edges++;

    always @(negedge clk) if (!idle) busy_cyc++;

    always_comb begin
        if (mdio_oe) mdio_i = mdio_o;
        else if (phy_on && rises >= 48 && rises <= 63) mdio_i = phy_data[63 - rises];
        else mdio_i = 1'b1;
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic clear_mon();
        rises = 0; period = 0; bad_edges = 0; busy_cyc = 0;
        cap = '0; oe_map = '0;
    endtask

    task automatic launch(input logic [1:0] sel, input logic [31:0] w);
        @(negedge clk);
        clk_sel = sel; wr_data = w; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 20000 && !idle; i++) @(negedge clk);
        @(negedge clk);
    endtask

    // stimulus table: clk_sel, word, phy present, phy data, expected readback
    localparam int NV = 5;
    localparam logic [1:0]  T_SEL [NV] = '{2'd0, 2'd1, 2'd2, 2'd3, 2'd0};
    localparam logic [31:0] T_WRD [NV] = '{32'h5192A5C3, 32'h60860000, 32'h6FFE0000,
                                           32'h5FFE8001, 32'h6086ABCD};
    localparam logic        T_PHY [NV] = '{1'b0, 1'b1, 1'b1, 1'b0, 1'b0};
    localparam logic [15:0] T_PDT [NV] = '{16'h0000, 16'h1234, 16'h8001, 16'h0000, 16'h0000};
    localparam logic [31:0] T_EXP [NV] = '{32'h5192A5C3, 32'h60861234, 32'h6FFE8001,
                                           32'h5FFE8001, 32'h6086FFFF};

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        rst = 1'b1; mgmt_en = 1'b0; clk_sel = 2'd0; wr_en = 1'b0; wr_data = '0;
        phy_on = 1'b0; phy_data = '0;
        clear_mon();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 reset idle/mdc/oe", {61'd0, idle, mdc, mdio_oe}, {61'd0, 3'b100});
        check("R1 reset readback", 64'(mgmt_rd), 64'd0);

        // R2 write with port disabled is ignored
        launch(2'd0, 32'h5192FFFF);
        check("R2 disabled write keeps idle", 64'(idle), 64'd1);
        repeat (100) @(negedge clk);
        check("R2 disabled write: no mdc edges", 64'(rises), 64'd0);
        check("R2 disabled write: readback unchanged", 64'(mgmt_rd), 64'd0);

        mgmt_en = 1'b1;
        for (int v = 0; v < NV; v++) begin
            logic is_rd;
            int   div;
            is_rd = (T_WRD[v][29:28] == 2'b10);
            div   = 8 << T_SEL[v];
            phy_on = T_PHY[v]; phy_data = T_PDT[v];
            clear_mon();
            launch(T_SEL[v], T_WRD[v]);
            check("R3 idle low after accept", 64'(idle), 64'd0);
            wait_idle();
            check("R3 busy cycles", 64'(busy_cyc), 64'(64 * div));
            check("R8 mdc period", 64'(period), 64'(div));
            check("R4 bit count", 64'(rises), 64'd64);
            check("R4 preamble", 64'(cap[63:32]), 64'hFFFFFFFF);
            check("R9 no change while mdc high", 64'(bad_edges), 64'd0);
            if (is_rd) begin
                check("R4 read header bits", 64'(cap[31:18]), 64'(T_WRD[v][31:18]));
                check("R6 oe map on read", oe_map, {46'h3FFFFFFFFFFF, 18'd0});
                if (T_PHY[v]) check("R6 read data", 64'(mgmt_rd), 64'(T_EXP[v]));
                else          check("R7 no PHY gives all ones", 64'(mgmt_rd), 64'(T_EXP[v]));
            end else begin
                check("R4 write frame bits", 64'(cap[31:0]), 64'(T_WRD[v]));
                check("R5 oe held on write", oe_map, 64'hFFFFFFFFFFFFFFFF);
                check("R5 readback after write", 64'(mgmt_rd), 64'(T_EXP[v]));
            end
        end

        // R10 write while busy is ignored
        phy_on = 1'b0;
        clear_mon();
        launch(2'd0, 32'h5192A5C3);
        repeat (40) @(negedge clk);
        launch(2'd1, 32'h60860000);
        wait_idle();
        check("R10 frame of first word", 64'(cap[31:0]), 64'h5192A5C3);
        check("R10 readback of first word", 64'(mgmt_rd), 64'h5192A5C3);
        check("R10 divider kept", 64'(period), 64'd8);

        // R1 reset returns to idle state mid-transaction
        launch(2'd2, 32'h5FFE8001);
        repeat (20) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset mid-frame", {29'd0, mgmt_rd, idle, mdc, mdio_oe}, {29'd0, 32'd0, 3'b100});

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule